// File: doc/BRIEF.md
# Streaming Link Receive Controller

This block terminates the receive side of a 32-bit parallel streaming link. It runs on the strobe that the source supplies. On each rising strobe edge it stores the word on the bus in a local FIFO when the active-low valid flag is low and the receiver is accepting. Stored words leave through a valid/ready interface, in the order they arrived.

Two active-low flow-control lines go back to the source. The not-ready line stays low through reset and until the local enable input is set. The suspend line goes low before the FIFO fills, early enough that the source can still send up to 16 words after it sees suspend. Suspend is released with hysteresis once the FIFO has drained to half full. If a word arrives while the FIFO is full, that word is lost and a sticky overflow flag is set.

An optional sync mode discards every word until the source pulses the active-low sync line. Acceptance then starts with the first valid period after that pulse.

Top module: `fprx_rx`

## Requirements
- R1: Each word captured while accepting appears on `out_data` in arrival order. A word leaves the FIFO only on a clock edge with `out_valid` and `out_ready` both high.
- R2: A rising edge with `link_valid_n` high stores nothing, whatever is on `link_data`.
- R3: `nrdy_n` follows `rx_enable` with one register delay and is low during reset. Words presented while `nrdy_n` is low are discarded.
- R4: One edge after the occupancy reaches DEPTH-18 or more (18 or fewer free entries), `suspend_n` is low.
- R5: After being driven low, `suspend_n` stays low while the occupancy is above DEPTH/2. It returns high one edge after the occupancy is DEPTH/2 or less.
- R6: A valid word that arrives while the FIFO holds DEPTH words is dropped and sets `overflow`. `overflow` stays high until reset.
- R7: With `sync_mode` high, words are discarded until an edge sees `link_sync_n` low. A word at that same edge is also discarded. Words are accepted from the next edge onward.
- R8: With `sync_mode` low, `link_sync_n` has no effect, and words are accepted as soon as `nrdy_n` is high.
- R9: `out_valid` is high exactly when the FIFO is not empty. While `out_valid` is high and `out_ready` is low, `out_data` holds steady.
- R10: After reset, `out_valid` is low, `suspend_n` is high, `nrdy_n` is low and `overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Strobe from the source; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_enable | input | 1 | Local permission to start receiving |
| sync_mode | input | 1 | High: wait for a sync pulse before accepting |
| link_data | input | 32 | Word on the link bus |
| link_valid_n | input | 1 | Low when `link_data` holds a word |
| link_sync_n | input | 1 | Active-low sync pulse from the source |
| nrdy_n | output | 1 | Low while the receiver cannot accept words |
| suspend_n | output | 1 | Low to ask the source to pause before the FIFO overflows |
| out_data | output | 32 | Oldest stored word |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Downstream takes `out_data` at this edge |
| overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
The bench builds the block with its defaults, which give the minimum depth of 64. At that depth a sweep can fill the FIFO one word at a time up to full and one word past it, then drain it back to empty. This means the suspend threshold at 46 words, the hysteresis band between 33 and 45 words, the drop at full and the arrival order of all 64 words are all checked at every occupancy. Separate short sequences cover sync gating, where the word that arrives with the pulse is discarded, and the not-ready gating after reset.

// File: rtl/fprx_pkg.sv
package fprx_pkg;

    // Width of one link word
    localparam int DATA_W       = 32;
    // Words the source may still send after it sees suspend
    localparam int SUSP_LATENCY = 16;
    // Extra slack for the registered suspend path
    localparam int PATH_MARGIN  = 2;
    // Free entries at or below which suspend is raised
    localparam int SUSP_FREE    = SUSP_LATENCY + PATH_MARGIN;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } link_word_t;

    typedef enum logic [1:0] {
        GATE_OPEN    = 2'b00,
        GATE_WAIT    = 2'b01,
        GATE_BLOCKED = 2'b10
    } gate_state_t;

    function automatic int unsigned free_slots(input int unsigned depth,
                                               input int unsigned level);
        return depth - level;
    endfunction

endpackage

// File: rtl/fprx_capture.sv
module fprx_capture
    import fprx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_mode,
    input  logic       accepting,
    input  logic       link_sync_n,
    input  link_word_t in_word,
    input  logic       fifo_full,
    output logic       wr_en,
    output logic       overflow
);

    logic        armed;
    gate_state_t gate;
    logic        want_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (!link_sync_n) begin
            armed <= 1'b1;
        end
    end

    always_comb begin
        if (!accepting)                gate = GATE_BLOCKED;
        else if (sync_mode && !armed)  gate = GATE_WAIT;
        else                           gate = GATE_OPEN;
    end

    assign want_write = in_word.valid && (gate == GATE_OPEN);
    assign wr_en      = want_write && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (want_write && fifo_full) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/fprx_fifo.sv
module fprx_fifo
    import fprx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              full,
    output logic [CNT_W-1:0]  level
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (level != '0);
    assign full      = (level == CNT_W'(DEPTH));
    assign do_rd     = rd_en && not_empty;
    assign rd_data   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({wr_en, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/fprx_flowctl.sv
module fprx_flowctl
    import fprx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SET_LEVEL = DEPTH - SUSP_FREE,
    localparam int CLR_LEVEL = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_enable,
    input  logic [CNT_W-1:0] level,
    output logic             nrdy_n,
    output logic             suspend_n
);

    logic susp_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            nrdy_n <= 1'b0;
        end else begin
            nrdy_n <= rx_enable;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            susp_active <= 1'b0;
        end else if (level >= CNT_W'(SET_LEVEL)) begin
            susp_active <= 1'b1;
        end else if (level <= CNT_W'(CLR_LEVEL)) begin
            susp_active <= 1'b0;
        end
    end

    assign suspend_n = !susp_active;

endmodule

// File: rtl/fprx_rx.sv
module fprx_rx
    import fprx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              sync_mode,
    input  logic [DATA_W-1:0] link_data,
    input  logic              link_valid_n,
    input  logic              link_sync_n,
    output logic              nrdy_n,
    output logic              suspend_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              overflow
);

    link_word_t       in_word;
    logic             wr_en;
    logic             fifo_full;
    logic [CNT_W-1:0] occ;

    assign in_word.valid = !link_valid_n;
    assign in_word.data  = link_data;

    fprx_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .sync_mode  (sync_mode),
        .accepting  (nrdy_n),
        .link_sync_n(link_sync_n),
        .in_word    (in_word),
        .fifo_full  (fifo_full),
        .wr_en      (wr_en),
        .overflow   (overflow)
    );

    fprx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (in_word.data),
        .rd_en    (out_ready),
        .rd_data  (out_data),
        .not_empty(out_valid),
        .full     (fifo_full),
        .level    (occ)
    );

    fprx_flowctl #(.DEPTH(DEPTH)) u_flow (
        .clk      (clk),
        .rst      (rst),
        .rx_enable(rx_enable),
        .level    (occ),
        .nrdy_n   (nrdy_n),
        .suspend_n(suspend_n)
    );

endmodule

// File: rtl/fprx_rx_checker.sv
module fprx_rx_checker #(
    parameter int DEPTH = 64,
    parameter int SUSP_FREE = 18,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_enable,
    input logic             nrdy_n,
    input logic             suspend_n,
    input logic [31:0]      out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             overflow,
    input logic [CNT_W-1:0] occ
);

    assert_nrdy_follows_R3: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !nrdy_n);

    assert_blocked_no_store_R3: assert property (@(posedge clk) disable iff (rst)
        (!nrdy_n && !out_valid) |=> !out_valid);

    assert_suspend_set_R4: assert property (@(posedge clk) disable iff (rst)
        (occ >= CNT_W'(DEPTH - SUSP_FREE)) |=> !suspend_n);

    assert_suspend_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (occ <= CNT_W'(DEPTH / 2)) |=> suspend_n);

    assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!suspend_n && occ > CNT_W'(DEPTH / 2)) |=> !suspend_n);

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_valid_level_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid == (occ != '0));

endmodule

bind fprx_rx fprx_rx_checker #(.DEPTH(DEPTH), .SUSP_FREE(fprx_pkg::SUSP_FREE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_enable(rx_enable),
    .nrdy_n   (nrdy_n),
    .suspend_n(suspend_n),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .overflow (overflow),
    .occ      (occ)
);

// File: tb/fprx_rx_tb.sv
`timescale 1ns/1ps
module fprx_rx_tb_top;

    localparam int DEPTH = 64;
    localparam int SET_LEVEL = DEPTH - 18;
    localparam int CLR_LEVEL = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b0;
    logic        sync_mode = 1'b0;
    logic [31:0] link_data = '0;
    logic        link_valid_n = 1'b1;
    logic        link_sync_n = 1'b1;
    logic        out_ready = 1'b0;
    logic        nrdy_n, suspend_n, out_valid, overflow;
    logic [31:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fprx_rx #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .sync_mode(sync_mode),
        .link_data(link_data), .link_valid_n(link_valid_n), .link_sync_n(link_sync_n),
        .nrdy_n(nrdy_n), .suspend_n(suspend_n), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .overflow(overflow)
    );

    function automatic logic [31:0] pattern(input int k);
        return 32'hC3A50000 ^ (k * 32'h9E3779B1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge with the given link inputs; returns after the next falling edge
    task automatic cyc(input bit vld, input logic [31:0] d, input bit sync, input bit rdy);
        link_valid_n = !vld;
        link_data    = d;
        link_sync_n  = !sync;
        out_ready    = rdy;
        @(negedge clk);
        link_valid_n = 1'b1;
        link_sync_n  = 1'b1;
        out_ready    = 1'b0;
    endtask

    task automatic do_reset(input bit smode);
        rst = 1'b1;
        rx_enable = 1'b0;
        sync_mode = smode;
        cyc(0, '0, 0, 0);
        cyc(0, '0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int occ;
        bit susp;
        @(negedge clk);
        do_reset(0);
        // R10 reset state
        chk("R10 out_valid", out_valid, 0);
        chk("R10 suspend_n", suspend_n, 1);
        chk("R10 nrdy_n", nrdy_n, 0);
        chk("R10 overflow", overflow, 0);

        // R3: disabled receiver drops words
        cyc(1, 32'h11111111, 0, 0);
        chk("R3 word dropped while not ready", out_valid, 0);
        rx_enable = 1'b1;
        cyc(0, '0, 0, 0);
        chk("R3 nrdy_n high after enable", nrdy_n, 1);

        // R2: invalid flag stores nothing
        cyc(0, 32'hDEADBEEF, 0, 0);
        chk("R2 no store with valid_n high", out_valid, 0);

        // R4 fill sweep with idle edge after each word
        occ = 0; susp = 0;
        for (int k = 0; k < DEPTH; k++) begin
            cyc(1, pattern(k), 0, 0);
            occ++;
            cyc(0, '0, 0, 0);
            if (occ >= SET_LEVEL) susp = 1;
            chk("R4 suspend_n during fill", suspend_n, !susp);
            chk("R9 out_valid during fill", out_valid, 1);
        end

        // R6: word at full is dropped
        chk("R6 overflow clear before drop", overflow, 0);
        cyc(1, 32'hBAD0BAD0, 0, 0);
        chk("R6 overflow set", overflow, 1);
        chk("R1 head unchanged after drop", out_data, pattern(0));

        // R1/R5 drain sweep
        for (int k = 0; k < DEPTH; k++) begin
            chk("R1 order", out_data, pattern(k));
            cyc(0, '0, 0, 0);
            chk("R9 data held without ready", out_data, pattern(k));
            cyc(0, '0, 0, 1);
            occ--;
            cyc(0, '0, 0, 0);
            if (occ <= CLR_LEVEL) susp = 0;
            chk("R5 suspend_n during drain", suspend_n, !susp);
        end
        chk("R9 empty after drain", out_valid, 0);
        chk("R6 overflow sticky", overflow, 1);

        // R7 sync gating
        do_reset(1);
        chk("R10 overflow cleared by reset", overflow, 0);
        rx_enable = 1'b1;
        cyc(0, '0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(1, pattern(100 + k), 0, 0);
        chk("R7 dropped before sync", out_valid, 0);
        cyc(1, 32'h5A5A0001, 1, 0);
        chk("R7 word with sync dropped", out_valid, 0);
        cyc(1, 32'h5A5A0002, 0, 0);
        chk("R7 first word after sync valid", out_valid, 1);
        chk("R7 first word after sync data", out_data, 32'h5A5A0002);
        cyc(0, '0, 0, 1);
        chk("R1 pop empties", out_valid, 0);

        // R8 sync ignored when sync_mode low
        do_reset(0);
        rx_enable = 1'b1;
        cyc(0, '0, 0, 0);
        cyc(1, 32'h77770001, 1, 0);
        chk("R8 accepted with sync low", out_data, 32'h77770001);
        cyc(1, 32'h77770002, 0, 0);
        chk("R8 still accepting", out_valid, 1);
        cyc(0, '0, 0, 1);
        chk("R8 second word order", out_data, 32'h77770002);

        finish_run();
    end

endmodule